// File: doc/BRIEF.md
# Pin Bank with Interrupt Sensing

A bank of up to 32 general-purpose pins behind a simple 32-bit register bus. Each pin can be used in one of three ways. It can be a plain input or a plain output, and in both cases its data goes through the bank's data registers. It can also be an interrupt source, and then its level or its edges are turned into status bits. The bank has one combined interrupt line. That line is raised when any status bit is set whose pin has been unmasked.

Pin inputs first pass through a two-flop synchroniser. They are then qualified by a per-pin input-enable bit, which resets to 0. Until software turns a pin on, that pin reads as zero and cannot raise an interrupt. For an edge-sensed pin, the event is latched until software acknowledges it. For a level-sensed pin, the status follows the qualified input directly. A build parameter chooses what the input-data register shows for pins set up as outputs.

Top module: `pio_bank`

## Requirements
- R1: After reset, every configuration register reads 0. This covers mode, direction, output data, polarity, edge select, both-edge, input enable and mask. `pin_oe` is all zeros and `irq` is 0.
- R2: `pin_out` equals the output-data register at offset 0x08. `pin_oe` bit n is 1 only when direction bit n is 1 (offset 0x04, 1 = output) and mode bit n is 0 (offset 0x00, 1 = interrupt input).
- R3: The input-data register at offset 0x0C shows a pin's level two clock edges after the pin changes. A pin whose input-enable bit is 0 reads as 0 there (input enable is at offset 0x50).
- R4: With the default parameter `DIN_SHOWS_PIN = 0`, a pin whose direction bit is 1 reads back its output-data bit at offset 0x0C instead of its pin level.
- R5: Level sensing is selected when edge-select bit n is 0 (offset 0x24). With polarity 0 (offset 0x20), status bit n at offset 0x10 equals the qualified pin level; with polarity 1 it equals the inverted level. The status follows the input and is not changed by writes to the acknowledge register at offset 0x14.
- R6: Edge sensing is selected when edge-select bit n is 1. With polarity 0, a rising edge latches status bit n; with polarity 1, a falling edge latches it. The bit stays set until a 1 is written to that bit at offset 0x14. Writing 0 there changes nothing.
- R7: When both-edge bit n is 1 (offset 0x4C), an edge-sensed pin latches status on either edge, whatever its polarity bit.
- R8: Writing to the mask register at offset 0x18 clears each mask bit whose written bit is 0 and ignores written 1 bits. Writing to offset 0x1C sets each mask bit whose written bit is 1. Offset 0x18 reads back the mask, where 1 means the pin is enabled.
- R9: `irq` is 1 exactly when some status bit and the matching mask bit are both 1.
- R10: A pin whose input-enable bit is 0 contributes no status, even when it is set to active-low level sensing with its pin held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 7 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| pin_in | input | NPINS | Pin levels from the pads |
| pin_out | output | NPINS | Output data to the pads |
| pin_oe | output | NPINS | Output enables to the pads |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is a latched edge that has to stay set after the pin has gone back to its idle level. A second hard case is a pin that is enabled for interrupts, active-low and held low, yet gated off by input enable.

The directed tasks reach these cases in two steps. First, the pins are moved only after the mode, polarity, edge and both-edge bits have been written. Second, the checks wait out the synchroniser and the latch stage before reading status. Each status read is then repeated around writes of zero and of one to the acknowledge register, and around toggles of input enable. This separates latched behaviour from followed behaviour.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned DATA_W = 32;

  // Register byte offsets (software-visible map)
  localparam logic [ADDR_W-1:0] OFS_MODE   = 7'h00;
  localparam logic [ADDR_W-1:0] OFS_DIR    = 7'h04;
  localparam logic [ADDR_W-1:0] OFS_DOUT   = 7'h08;
  localparam logic [ADDR_W-1:0] OFS_DIN    = 7'h0C;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 7'h10;
  localparam logic [ADDR_W-1:0] OFS_ACK    = 7'h14;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 7'h18;
  localparam logic [ADDR_W-1:0] OFS_UNMASK = 7'h1C;
  localparam logic [ADDR_W-1:0] OFS_POL    = 7'h20;
  localparam logic [ADDR_W-1:0] OFS_EDGE   = 7'h24;
  localparam logic [ADDR_W-1:0] OFS_BOTH   = 7'h4C;
  localparam logic [ADDR_W-1:0] OFS_INEN   = 7'h50;
endpackage

// File: rtl/pio_rst_sync.sv
module pio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/pio_detect.sv
module pio_detect #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sync_in,
  input  logic [N-1:0] inen,
  input  logic [N-1:0] mode,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] edge_sel,
  input  logic [N-1:0] both,
  input  logic [N-1:0] ack,
  output logic [N-1:0] status,
  output logic [N-1:0] lat_q
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic prev_q;
    logic lat_r;
    logic lat_d;
    logic rise;
    logic fall;
    logic evt;

    always_comb begin
      rise  = sync_in[g] & ~prev_q;
      fall  = ~sync_in[g] & prev_q;
      evt   = inen[g] & mode[g] & edge_sel[g] &
              (both[g] ? (rise | fall) : (pol[g] ? fall : rise));
      lat_d = lat_r;
      if (ack[g]) lat_d = 1'b0;
      if (evt)    lat_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        lat_r  <= 1'b0;
      end else begin
        prev_q <= sync_in[g];
        lat_r  <= lat_d;
      end
    end

    assign lat_q[g]  = lat_r;
    assign status[g] = mode[g] & inen[g] &
                       (edge_sel[g] ? lat_r : (sync_in[g] ^ pol[g]));
  end
endmodule

// File: rtl/pio_bank.sv
module pio_bank
  import pio_pkg::*;
#(
  parameter int unsigned NPINS         = 32,
  parameter bit          DIN_SHOWS_PIN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  logic srst_n;
  logic [NPINS-1:0] wr_v;
  logic [NPINS-1:0] mode_q, mode_d, dir_q, dir_d, dout_q, dout_d;
  logic [NPINS-1:0] pol_q, pol_d, edge_q, edge_d, both_q, both_d;
  logic [NPINS-1:0] inen_q, inen_d, mask_q, mask_d;
  logic [NPINS-1:0] ack_v, sync_v, qual_v, din_v, status, lat_q;
  logic [NPINS-1:0] rd_v;

  pio_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(srst_n));

  pio_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(srst_n), .d(pin_in), .q(sync_v)
  );

  assign wr_v  = bus_wdata[NPINS-1:0];
  assign ack_v = (bus_wr && bus_addr == OFS_ACK) ? wr_v : '0;

  // Next-state for configuration registers
  always_comb begin
    mode_d = mode_q;
    dir_d  = dir_q;
    dout_d = dout_q;
    pol_d  = pol_q;
    edge_d = edge_q;
    both_d = both_q;
    inen_d = inen_q;
    mask_d = mask_q;
    if (bus_wr) begin
      unique case (bus_addr)
        OFS_MODE:   mode_d = wr_v;
        OFS_DIR:    dir_d  = wr_v;
        OFS_DOUT:   dout_d = wr_v;
        OFS_POL:    pol_d  = wr_v;
        OFS_EDGE:   edge_d = wr_v;
        OFS_BOTH:   both_d = wr_v;
        OFS_INEN:   inen_d = wr_v;
        OFS_MASK:   mask_d = mask_q & wr_v;
        OFS_UNMASK: mask_d = mask_q | wr_v;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      mode_q <= '0;
      dir_q  <= '0;
      dout_q <= '0;
      pol_q  <= '0;
      edge_q <= '0;
      both_q <= '0;
      inen_q <= '0;
      mask_q <= '0;
    end else begin
      mode_q <= mode_d;
      dir_q  <= dir_d;
      dout_q <= dout_d;
      pol_q  <= pol_d;
      edge_q <= edge_d;
      both_q <= both_d;
      inen_q <= inen_d;
      mask_q <= mask_d;
    end
  end

  pio_detect #(.N(NPINS)) u_det (
    .clk(clk), .rst_n(srst_n), .sync_in(sync_v), .inen(inen_q),
    .mode(mode_q), .pol(pol_q), .edge_sel(edge_q), .both(both_q),
    .ack(ack_v), .status(status), .lat_q(lat_q)
  );

  assign qual_v = sync_v & inen_q;

  if (DIN_SHOWS_PIN) begin : g_din_pin
    assign din_v = qual_v;
  end else begin : g_din_mix
    assign din_v = (dir_q & dout_q) | (~dir_q & qual_v);
  end

  always_comb begin
    unique case (bus_addr)
      OFS_MODE:   rd_v = mode_q;
      OFS_DIR:    rd_v = dir_q;
      OFS_DOUT:   rd_v = dout_q;
      OFS_DIN:    rd_v = din_v;
      OFS_STAT:   rd_v = status;
      OFS_MASK:   rd_v = mask_q;
      OFS_POL:    rd_v = pol_q;
      OFS_EDGE:   rd_v = edge_q;
      OFS_BOTH:   rd_v = both_q;
      OFS_INEN:   rd_v = inen_q;
      default:    rd_v = '0;
    endcase
    bus_rdata = '0;
    bus_rdata[NPINS-1:0] = rd_v;
  end

  assign pin_out = dout_q;
  assign pin_oe  = dir_q & ~mode_q;
  assign irq     = |(status & mask_q);
endmodule

// File: rtl/pio_bank_chk.sv
module pio_bank_chk
  import pio_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [NPINS-1:0]  pin_oe,
  input logic              irq,
  input logic [NPINS-1:0]  mode_q,
  input logic [NPINS-1:0]  inen_q,
  input logic [NPINS-1:0]  mask_q,
  input logic [NPINS-1:0]  lat_q
);
  // R2: a pin in interrupt mode never drives
  a_r2_no_drive_in_irq_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & mode_q) == '0);

  // R8: a write to the mask register never sets a bit
  a_r8_mask_write_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_MASK) |=> ((mask_q & ~$past(mask_q)) == '0));

  // R8: a write to the unmask register sets every written 1
  a_r8_unmask_sets_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_UNMASK) |=>
      ((mask_q & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0])));

  // R6: latched edge bits only drop through an acknowledge write
  a_r6_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == OFS_ACK) |=> ((lat_q & $past(lat_q)) == $past(lat_q)));

  // R10 / R9: a request needs an enabled, unmasked interrupt pin
  a_r10_irq_needs_enabled_pin: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((mask_q & inen_q & mode_q) != '0));
endmodule

bind pio_bank pio_bank_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pin_oe(pin_oe), .irq(irq), .mode_q(mode_q),
  .inen_q(inen_q), .mask_q(mask_q), .lat_q(lat_q)
);

// File: tb/sim_pio_bank.sv
`timescale 1ns/1ps
module sim_pio_bank;
  import pio_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic [31:0]       pin_in = '0;
  logic [31:0]       pin_out;
  logic [31:0]       pin_oe;
  logic              irq;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  pio_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic drive_pins(input logic [31:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(OFS_MODE, v); chk("R1 mode", v, 32'h0);
    rd(OFS_MASK, v); chk("R1 mask", v, 32'h0);
    rd(OFS_INEN, v); chk("R1 inen", v, 32'h0);
    rd(OFS_DIR, v);  chk("R1 dir", v, 32'h0);
    chk("R1 pin_oe", pin_oe, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_output();
    logic [31:0] v;
    wr(OFS_DOUT, 32'h0000_00A5);
    wr(OFS_DIR, 32'h0000_000F);
    chk("R2 pin_oe", pin_oe, 32'h0000_000F);
    chk("R2 pin_out", pin_out, 32'h0000_00A5);
    wr(OFS_INEN, 32'h0000_00FF);
    drive_pins(32'h0000_005A);
    rd(OFS_DIN, v); chk("R4 output readback", v, 32'h0000_0055);
    wr(OFS_MODE, 32'h0000_0001);
    chk("R2 oe off in irq mode", pin_oe, 32'h0000_000E);
    wr(OFS_MODE, 32'h0);
    wr(OFS_DIR, 32'h0);
    drive_pins(32'h0);
  endtask

  task automatic t_input();
    logic [31:0] v;
    wr(OFS_INEN, 32'h0000_000F);
    @(negedge clk);
    pin_in = 32'h0000_00FF;
    @(negedge clk);
    rd(OFS_DIN, v); chk("R3 not yet through sync", v, 32'h0);
    @(negedge clk);
    rd(OFS_DIN, v); chk("R3 after two edges, gated", v, 32'h0000_000F);
    drive_pins(32'h0);
    wr(OFS_INEN, 32'hFFFF_FFFF);
  endtask

  task automatic t_level();
    logic [31:0] v;
    wr(OFS_MODE, 32'h0000_0100);
    wr(OFS_UNMASK, 32'h0000_0100);
    rd(OFS_STAT, v); chk("R5 low input idle", v, 32'h0);
    drive_pins(32'h0000_0100);
    rd(OFS_STAT, v); chk("R5 active high", v, 32'h0000_0100);
    chk("R9 irq level", {31'h0, irq}, 32'h1);
    wr(OFS_ACK, 32'h0000_0100);
    rd(OFS_STAT, v); chk("R5 ack has no effect", v, 32'h0000_0100);
    drive_pins(32'h0);
    rd(OFS_STAT, v); chk("R5 follows input", v, 32'h0);
    chk("R9 irq drops", {31'h0, irq}, 32'h0);
    wr(OFS_POL, 32'h0000_0100);
    rd(OFS_STAT, v); chk("R5 active low", v, 32'h0000_0100);
    wr(OFS_MASK, 32'hFFFF_FEFF);
    wr(OFS_POL, 32'h0);
    wr(OFS_MODE, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    wr(OFS_EDGE, 32'h0000_0200);
    wr(OFS_MODE, 32'h0000_0200);
    drive_pins(32'h0000_0200);
    rd(OFS_STAT, v); chk("R6 rising latched", v, 32'h0000_0200);
    drive_pins(32'h0);
    rd(OFS_STAT, v); chk("R6 held after pin returns", v, 32'h0000_0200);
    wr(OFS_ACK, 32'h0);
    rd(OFS_STAT, v); chk("R6 zero write no effect", v, 32'h0000_0200);
    wr(OFS_ACK, 32'h0000_0200);
    rd(OFS_STAT, v); chk("R6 cleared by one", v, 32'h0);
    wr(OFS_POL, 32'h0000_0200);
    drive_pins(32'h0000_0200);
    rd(OFS_STAT, v); chk("R6 rise ignored when falling", v, 32'h0);
    drive_pins(32'h0);
    rd(OFS_STAT, v); chk("R6 falling latched", v, 32'h0000_0200);
    wr(OFS_ACK, 32'h0000_0200);
    wr(OFS_POL, 32'h0);
    wr(OFS_MODE, 32'h0);
    wr(OFS_EDGE, 32'h0);
  endtask

  task automatic t_both();
    logic [31:0] v;
    wr(OFS_EDGE, 32'h0000_0400);
    wr(OFS_BOTH, 32'h0000_0400);
    wr(OFS_POL, 32'h0000_0400);
    wr(OFS_MODE, 32'h0000_0400);
    drive_pins(32'h0000_0400);
    rd(OFS_STAT, v); chk("R7 rise despite polarity", v, 32'h0000_0400);
    wr(OFS_ACK, 32'h0000_0400);
    drive_pins(32'h0);
    rd(OFS_STAT, v); chk("R7 fall", v, 32'h0000_0400);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    chk("R9 masked no irq", {31'h0, irq}, 32'h0);
    wr(OFS_UNMASK, 32'h0000_0400);
    rd(OFS_MASK, v); chk("R8 unmask", v, 32'h0000_0400);
    chk("R9 irq unmasked", {31'h0, irq}, 32'h1);
    wr(OFS_MASK, 32'hFFFF_FFFF);
    rd(OFS_MASK, v); chk("R8 ones ignored", v, 32'h0000_0400);
    wr(OFS_MASK, 32'hFFFF_FBFF);
    rd(OFS_MASK, v); chk("R8 zero masks", v, 32'h0);
    chk("R9 irq masked again", {31'h0, irq}, 32'h0);
    wr(OFS_UNMASK, 32'h0000_0003);
    wr(OFS_MASK, 32'hFFFF_FFFE);
    rd(OFS_MASK, v); chk("R8 selective", v, 32'h0000_0002);
    wr(OFS_ACK, 32'h0000_0400);
    wr(OFS_MODE, 32'h0);
    wr(OFS_MASK, 32'h0);
  endtask

  task automatic t_inen();
    logic [31:0] v;
    wr(OFS_POL, 32'h0000_0800);
    wr(OFS_INEN, 32'hFFFF_F7FF);
    wr(OFS_MODE, 32'h0000_0800);
    wr(OFS_UNMASK, 32'h0000_0800);
    drive_pins(32'h0000_0800);
    rd(OFS_DIN, v); chk("R3 disabled pin reads 0", v, 32'h0);
    drive_pins(32'h0);
    rd(OFS_STAT, v); chk("R10 no status when disabled", v, 32'h0);
    chk("R10 no irq when disabled", {31'h0, irq}, 32'h0);
    wr(OFS_INEN, 32'hFFFF_FFFF);
    rd(OFS_STAT, v); chk("R10 enabled active low", v, 32'h0000_0800);
    chk("R9 irq enabled", {31'h0, irq}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_output();
    t_input();
    t_level();
    t_edge();
    t_both();
    t_mask();
    t_inen();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule